// File: doc/BRIEF.md
# Transactional Store Buffer with Atomic Commit Packer

This block sits beside one processor core and gathers every store the core makes while a transaction is running. Stores are kept in a private buffer, apart from the cache and away from shared memory. A tag list records which addresses hold data that must be committed. A repeat store to an address already held replaces that entry's data, so the list only grows on new addresses.

The transaction end is signalled by a one-cycle strobe. The block then raises a request toward a system arbiter and waits. Nothing leaves the block until a grant arrives. After the grant, the whole write set goes out back to back as one packet. The first beat is a header holding the entry count and the transaction's ordering numbers. Each later beat carries one address and its data, and the final beat is flagged. This gives one arbitration and one message per transaction.

If the tag list fills up before the transaction ends, the block raises its full flag, stalls further stores and requests commit on its own. An abort input empties the buffer and withdraws any pending request in one cycle. Once a packet has started, an abort no longer affects it.

Top module: `txn_commit_buffer`

## Requirements
- R1: A store is taken when `stValid` and `stReady` are both high at a clock edge. It is held inside the block, and `pktValid` stays low until a commit grant has been seen.
- R2: A store to an address already in the buffer replaces that entry's data and adds no entry. The packet then carries that address once, with the latest data.
- R3: `full` is high exactly when DEPTH distinct addresses are buffered. `stReady` is low while `full` is high and while a request or packet is in progress.
- R4: `commitReq` rises in the cycle after a `txnEnd` strobe is taken. It stays high until a grant or an abort.
- R5: Packet beats start only after a grant. The header beat appears in the cycle after the edge at which `commitGnt` is sampled high while `commitReq` is high. `commitReq` and `pktValid` are never high together.
- R6: The header beat has `pktStart`=1 and `pktHdr`=1, and `pktAddr` is zero. In `pktData`, bits [CNT_W-1:0] hold the entry count, the next PHASE_W bits hold the phase number, the next SEQ_W bits hold the sequence number, and every other bit is zero. CNT_W is $clog2(DEPTH+1). Sequence and phase are sampled at the edge where the request begins.
- R7: Entry beats follow the header on consecutive cycles, in the order the addresses were first stored, with `pktHdr`=0. The final beat has `pktEnd`=1. A transaction with no stores sends a header only, and that beat has both `pktStart` and `pktEnd` high.
- R8: In the cycle after the final beat, the buffer is empty, `full` is low and `stReady` is high.
- R9: An abort while idle or requesting clears the buffer and drops `commitReq` by the next cycle. A store or `txnEnd` in the same cycle as the abort is ignored. An abort during a packet is ignored.
- R10: When the tag list fills with no `txnEnd`, `commitReq` rises in the cycle after `full` rises. This is a forced early commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 1 | Store present |
| stAddr | input | ADDR_W | Store address |
| stData | input | DATA_W | Store data |
| stReady | output | 1 | Store can be taken this cycle |
| txnEnd | input | 1 | One-cycle strobe: transaction finished |
| txnSeq | input | SEQ_W | Sequence number of the current transaction |
| txnPhase | input | PHASE_W | Phase number of the current transaction |
| abort | input | 1 | Discard the transaction's buffered writes |
| full | output | 1 | Tag list at capacity |
| commitReq | output | 1 | Request for commit permission |
| commitGnt | input | 1 | Commit permission granted |
| pktValid | output | 1 | Packet beat present |
| pktStart | output | 1 | First beat of the packet |
| pktEnd | output | 1 | Last beat of the packet |
| pktHdr | output | 1 | Beat is the header |
| pktAddr | output | ADDR_W | Beat address (zero on header) |
| pktData | output | DATA_W | Beat data or header word |

## Verification
Each result has a fixed due cycle. `commitReq` is due one edge after `txnEnd` is taken, or one edge after `full` rises. The header is due one edge after the grant is sampled, and entry n follows n edges after that. The drained state is due one edge after the final beat. The bench drives its inputs one time unit after a rising edge. A monitor compares every beat with the head of an expected-beat queue at the falling edge. Direct checks wait the exact number of rising edges counted above and then sample a few time units later, so no check is taken on an edge.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_SEND = 2'd2
  } tcbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic storeEn;   // take the presented store
    logic clearAll;  // empty tag list and data buffer
    logic latchHdr;  // capture sequence and phase numbers
    logic beatOn;    // a packet beat is on the output
    logic hdrBeat;   // that beat is the header
  } tcbCtl_t;

endpackage

// File: rtl/tcb_datapath.sv
module tcb_datapath
  import tcb_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 8,
  parameter int SEQ_W   = 8,
  parameter int PHASE_W = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  tcbCtl_t                    ctl,
  input  logic [$clog2(DEPTH)-1:0]   rdIdx,
  input  logic [ADDR_W-1:0]          stAddr,
  input  logic [DATA_W-1:0]          stData,
  input  logic [SEQ_W-1:0]           txnSeq,
  input  logic [PHASE_W-1:0]         txnPhase,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic [ADDR_W-1:0]          pktAddr,
  output logic [DATA_W-1:0]          pktData
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [ADDR_W-1:0]  tagQ  [DEPTH];
  logic [DATA_W-1:0]  dataQ [DEPTH];
  logic [DEPTH-1:0]   hitVec;
  logic               anyHit;
  logic [SEQ_W-1:0]   seqQ;
  logic [PHASE_W-1:0] phaseQ;
  logic [DATA_W-1:0]  hdrWord;
  logic               appendEn;

  assign full     = (count == CNT_W'(DEPTH));
  assign anyHit   = |hitVec;
  assign appendEn = ctl.storeEn && !anyHit && !full;

  // tag match against the valid part of the list, one comparator per entry
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      assign hitVec[i] = (CNT_W'(i) < count) && (tagQ[i] == stAddr);

      always_ff @(posedge clk) begin
        if (ctl.storeEn && hitVec[i]) begin
          dataQ[i] <= stData;
        end else if (appendEn && (count == CNT_W'(i))) begin
          tagQ[i]  <= stAddr;
          dataQ[i] <= stData;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (ctl.clearAll) begin
      count <= '0;
    end else if (appendEn) begin
      count <= count + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqQ   <= '0;
      phaseQ <= '0;
    end else if (ctl.latchHdr) begin
      seqQ   <= txnSeq;
      phaseQ <= txnPhase;
    end
  end

  always_comb begin
    hdrWord = '0;
    hdrWord[CNT_W-1:0]               = count;
    hdrWord[CNT_W +: PHASE_W]        = phaseQ;
    hdrWord[CNT_W+PHASE_W +: SEQ_W]  = seqQ;
  end

  always_comb begin
    pktAddr = '0;
    pktData = '0;
    if (ctl.beatOn) begin
      if (ctl.hdrBeat) begin
        pktData = hdrWord;
      end else begin
        pktAddr = tagQ[rdIdx];
        pktData = dataQ[rdIdx];
      end
    end
  end

  // IDX_W kept for readers of the port width
  logic unusedIdx;
  assign unusedIdx = ^{IDX_W{1'b0}};

endmodule

// File: rtl/tcb_control.sv
module tcb_control
  import tcb_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       stValid,
  input  logic                       txnEnd,
  input  logic                       abort,
  input  logic                       commitGnt,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  logic                       full,
  output tcbCtl_t                    ctl,
  output logic [$clog2(DEPTH)-1:0]   rdIdx,
  output logic                       stReady,
  output logic                       commitReq,
  output logic                       pktValid,
  output logic                       pktStart,
  output logic                       pktEnd,
  output logic                       pktHdr
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  tcbState_t        state, stateNx;
  logic [CNT_W-1:0] beatQ;
  logic             lastBeat;
  logic             inSend;

  assign inSend    = (state == ST_SEND);
  assign lastBeat  = inSend && (beatQ == count);
  assign stReady   = (state == ST_IDLE) && !full;
  assign commitReq = (state == ST_REQ);
  assign pktValid  = inSend;
  assign pktStart  = inSend && (beatQ == '0);
  assign pktHdr    = pktStart;
  assign pktEnd    = lastBeat;
  assign rdIdx     = IDX_W'(beatQ - CNT_W'(1));

  always_comb begin
    stateNx      = state;
    ctl          = '0;
    ctl.storeEn  = stValid && stReady && !abort;
    ctl.beatOn   = inSend;
    ctl.hdrBeat  = pktStart;
    unique case (state)
      ST_IDLE: begin
        if (abort) begin
          ctl.clearAll = 1'b1;
        end else if (txnEnd || full) begin
          ctl.latchHdr = 1'b1;
          stateNx      = ST_REQ;
        end
      end
      ST_REQ: begin
        if (abort) begin
          ctl.clearAll = 1'b1;
          stateNx      = ST_IDLE;
        end else if (commitGnt) begin
          stateNx = ST_SEND;
        end
      end
      ST_SEND: begin
        if (lastBeat) begin
          ctl.clearAll = 1'b1;
          stateNx      = ST_IDLE;
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      beatQ <= '0;
    end else begin
      state <= stateNx;
      if (inSend && !lastBeat) begin
        beatQ <= beatQ + CNT_W'(1);
      end else begin
        beatQ <= '0;
      end
    end
  end

endmodule

// File: rtl/txn_commit_buffer.sv
module txn_commit_buffer
  import tcb_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 8,
  parameter int SEQ_W   = 8,
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stValid,
  input  logic [ADDR_W-1:0]  stAddr,
  input  logic [DATA_W-1:0]  stData,
  output logic               stReady,
  input  logic               txnEnd,
  input  logic [SEQ_W-1:0]   txnSeq,
  input  logic [PHASE_W-1:0] txnPhase,
  input  logic               abort,
  output logic               full,
  output logic               commitReq,
  input  logic               commitGnt,
  output logic               pktValid,
  output logic               pktStart,
  output logic               pktEnd,
  output logic               pktHdr,
  output logic [ADDR_W-1:0]  pktAddr,
  output logic [DATA_W-1:0]  pktData
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  tcbCtl_t          ctl;
  logic [IDX_W-1:0] rdIdx;
  logic [CNT_W-1:0] count;

  tcb_control #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .stValid   (stValid),
    .txnEnd    (txnEnd),
    .abort     (abort),
    .commitGnt (commitGnt),
    .count     (count),
    .full      (full),
    .ctl       (ctl),
    .rdIdx     (rdIdx),
    .stReady   (stReady),
    .commitReq (commitReq),
    .pktValid  (pktValid),
    .pktStart  (pktStart),
    .pktEnd    (pktEnd),
    .pktHdr    (pktHdr)
  );

  tcb_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .SEQ_W  (SEQ_W),
    .PHASE_W(PHASE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .rdIdx    (rdIdx),
    .stAddr   (stAddr),
    .stData   (stData),
    .txnSeq   (txnSeq),
    .txnPhase (txnPhase),
    .count    (count),
    .full     (full),
    .pktAddr  (pktAddr),
    .pktData  (pktData)
  );

endmodule

// File: rtl/tcb_checker.sv
module tcb_checker (
  input logic clk,
  input logic rstN,
  input logic stReady,
  input logic txnEnd,
  input logic abort,
  input logic full,
  input logic commitReq,
  input logic commitGnt,
  input logic pktValid,
  input logic pktStart,
  input logic pktEnd,
  input logic pktHdr
);

  assert_full_stalls_R3: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !stReady);

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    commitReq && !commitGnt && !abort |=> commitReq);

  assert_end_requests_R4: assert property (@(posedge clk) disable iff (!rstN)
    txnEnd && stReady && !abort |=> commitReq);

  assert_req_not_beat_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(commitReq && pktValid));

  assert_grant_header_R5: assert property (@(posedge clk) disable iff (!rstN)
    commitReq && commitGnt && !abort |=> pktValid && pktStart && pktHdr);

  assert_start_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pktStart || pktHdr || pktEnd) |-> pktValid);

  assert_beats_contig_R7: assert property (@(posedge clk) disable iff (!rstN)
    pktValid && !pktEnd |=> pktValid && !pktStart && !pktHdr);

  assert_drained_R8: assert property (@(posedge clk) disable iff (!rstN)
    pktEnd |=> !pktValid && !full && stReady);

  assert_abort_drops_R9: assert property (@(posedge clk) disable iff (!rstN)
    abort && !pktValid |=> !commitReq && !full && !pktValid);

  assert_forced_commit_R10: assert property (@(posedge clk) disable iff (!rstN)
    full && !commitReq && !pktValid && !abort |=> commitReq);

endmodule

bind txn_commit_buffer tcb_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .stReady   (stReady),
  .txnEnd    (txnEnd),
  .abort     (abort),
  .full      (full),
  .commitReq (commitReq),
  .commitGnt (commitGnt),
  .pktValid  (pktValid),
  .pktStart  (pktStart),
  .pktEnd    (pktEnd),
  .pktHdr    (pktHdr)
);

// File: tb/txn_commit_buffer_tb.sv
module txn_commit_buffer_tb;

  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;
  localparam int DEPTH   = 8;
  localparam int SEQ_W   = 8;
  localparam int PHASE_W = 4;

  typedef struct packed {
    logic              s;
    logic              e;
    logic              h;
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d;
  } beat_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stValid = 1'b0;
  logic [ADDR_W-1:0] stAddr = '0;
  logic [DATA_W-1:0] stData = '0;
  logic stReady;
  logic txnEnd = 1'b0;
  logic [SEQ_W-1:0] txnSeq = '0;
  logic [PHASE_W-1:0] txnPhase = '0;
  logic abort = 1'b0;
  logic full, commitReq;
  logic commitGnt = 1'b0;
  logic pktValid, pktStart, pktEnd, pktHdr;
  logic [ADDR_W-1:0] pktAddr;
  logic [DATA_W-1:0] pktData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  beat_t expQ[$];
  logic [ADDR_W-1:0] mA[$];
  logic [DATA_W-1:0] mD[$];

  always #4 clk = ~clk;

  txn_commit_buffer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
    .SEQ_W(SEQ_W), .PHASE_W(PHASE_W)
  ) u_dut (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stAddr(stAddr),
    .stData(stData), .stReady(stReady), .txnEnd(txnEnd), .txnSeq(txnSeq),
    .txnPhase(txnPhase), .abort(abort), .full(full), .commitReq(commitReq),
    .commitGnt(commitGnt), .pktValid(pktValid), .pktStart(pktStart),
    .pktEnd(pktEnd), .pktHdr(pktHdr), .pktAddr(pktAddr), .pktData(pktData)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every beat is compared with the queue head
  always @(negedge clk) begin
    if (rstN && pktValid) begin
      beat_t got;
      beat_t want;
      got = '{s:pktStart, e:pktEnd, h:pktHdr, a:pktAddr, d:pktData};
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R5: actual=%0h expected=no beat", got);
      end else begin
        want = expQ.pop_front();
        if (got !== want) begin
          errors++;
          $display("FAIL %s: actual=%0h expected=%0h", want.h ? "R6" : "R7", got, want);
        end
      end
    end
  end

  function automatic logic [DATA_W-1:0] hdrWord(int n, logic [SEQ_W-1:0] sq, logic [PHASE_W-1:0] ph);
    return {16'h0, sq, ph, 4'(n)};
  endfunction

  task automatic modelStore(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    for (int i = 0; i < mA.size(); i++) begin
      if (mA[i] == a) begin
        mD[i] = d;
        return;
      end
    end
    mA.push_back(a);
    mD.push_back(d);
  endtask

  // called one time unit after a rising edge; returns the same way
  task automatic doStore(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    stValid = 1'b1; stAddr = a; stData = d;
    @(posedge clk); #1;
    stValid = 1'b0;
    modelStore(a, d);
  endtask

  task automatic endTxn(input logic [SEQ_W-1:0] sq, input logic [PHASE_W-1:0] ph);
    txnSeq = sq; txnPhase = ph; txnEnd = 1'b1;
    @(posedge clk); #1;
    txnEnd = 1'b0;
    chk("R4 req after end", commitReq, 1);
  endtask

  task automatic grantRun(input logic [SEQ_W-1:0] sq, input logic [PHASE_W-1:0] ph, input bit abortMid);
    int n;
    n = mA.size();
    expQ.push_back('{s:1'b1, e:(n == 0), h:1'b1, a:'0, d:hdrWord(n, sq, ph)});
    for (int i = 0; i < n; i++)
      expQ.push_back('{s:1'b0, e:(i == n-1), h:1'b0, a:mA[i], d:mD[i]});
    mA.delete(); mD.delete();
    commitGnt = 1'b1;
    @(posedge clk); #1;
    commitGnt = 1'b0;
    for (int k = 0; k < n + 1; k++) begin
      @(posedge clk);
      if (abortMid && k == 0) begin #1; abort = 1'b1; end
      if (abortMid && k == 1) begin #1; abort = 1'b0; end
    end
    #2;
    chk("R7 all beats sent", expQ.size(), 0);
    chk("R8 no beat after end", pktValid, 0);
    chk("R8 full low", full, 0);
    chk("R8 ready again", stReady, 1);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #2;
    chk("R4 reset req", commitReq, 0);
    chk("R5 reset beat", pktValid, 0);
    chk("R3 reset full", full, 0);
    chk("R3 reset ready", stReady, 1);

    // R1/R2: distinct stores then an overwrite
    @(posedge clk); #1;
    doStore(16'h0040, 32'hA000_0001);
    doStore(16'h0044, 32'hA000_0002);
    doStore(16'h0048, 32'hA000_0003);
    doStore(16'h0044, 32'hB000_0022);
    chk("R1 held until grant", pktValid, 0);
    endTxn(8'h05, 4'h2);
    chk("R3 stall during request", stReady, 0);
    repeat (3) begin
      @(posedge clk); #1;
      chk("R4 req held", commitReq, 1);
      chk("R5 nothing before grant", pktValid, 0);
    end
    grantRun(8'h05, 4'h2, 1'b0);  // R2 count 3, latest data on 0x44

    // R7: empty transaction, header only
    endTxn(8'hA1, 4'hF);
    grantRun(8'hA1, 4'hF, 1'b0);

    // R9: abort in request state
    doStore(16'h0100, 32'h1111_1111);
    doStore(16'h0104, 32'h2222_2222);
    endTxn(8'h09, 4'h1);
    abort = 1'b1;
    @(posedge clk); #1;
    abort = 1'b0;
    mA.delete(); mD.delete();
    chk("R9 request dropped", commitReq, 0);
    chk("R9 ready after abort", stReady, 1);
    // R9: store and txnEnd in the same cycle as abort are ignored
    stValid = 1'b1; stAddr = 16'h0200; stData = 32'h3333_3333;
    txnEnd = 1'b1; abort = 1'b1;
    @(posedge clk); #1;
    stValid = 1'b0; txnEnd = 1'b0; abort = 1'b0;
    chk("R9 end ignored with abort", commitReq, 0);
    endTxn(8'h0A, 4'h3);
    grantRun(8'h0A, 4'h3, 1'b0);   // header count 0 proves the buffer was emptied

    // R10/R3: forced early commit on a full list; R6 latched numbers
    txnSeq = 8'h33; txnPhase = 4'h7;
    for (int i = 0; i < DEPTH; i++)
      doStore(16'h0300 + 16'(i * 4), 32'hC000_0000 + 32'(i));
    chk("R3 full at capacity", full, 1);
    chk("R3 stall when full", stReady, 0);
    chk("R10 not yet requesting", commitReq, 0);
    @(posedge clk); #1;
    chk("R10 forced request", commitReq, 1);
    txnSeq = 8'hEE; txnPhase = 4'h0;
    @(posedge clk); #1;
    chk("R5 no beat before grant", pktValid, 0);
    grantRun(8'h33, 4'h7, 1'b0);

    // R9: abort during a packet has no effect
    doStore(16'h0500, 32'hD000_0001);
    doStore(16'h0504, 32'hD000_0002);
    doStore(16'h0508, 32'hD000_0003);
    endTxn(8'h44, 4'h4);
    grantRun(8'h44, 4'h4, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule